// File: doc/BRIEF.md
# Acknowledging Two-Wire Display Slave

This block is a receive-and-readback slave on a two-wire serial bus that feeds a 128-bit display word. A bus controller opens a transfer with a start condition and sends an address byte. The upper seven bits of that byte are compared with a configured device address, and the lowest bit picks the direction. A matching slave acknowledges by pulling the data line low during the ninth clock.

In write direction, the controller sends data bytes. The slave acknowledges each one, and the bits collect in a 128-bit shift register. The visible display word loads from that register in one of two ways. With the enable input held high, it loads when a full block of 128 bits has arrived. With the enable input held low, it loads on a low-to-high pulse of the enable input while the clock line is high. After a block completes, the next rising clock edge is treated as a spare edge and skipped, so that data streams on without a new start. In read direction, the slave returns the shift register oldest bit first. It releases the line on every ninth clock and stops when the controller does not acknowledge.

The bus inputs are expected to be already synchronised to the system clock. The data output is an open-drain pull-down enable, and it changes only while the clock line is low.

Top module: `disp_2w_slave`

## Requirements
- R1: While and after reset, `disp_o` is all zeros and `sda_pd_o` is 0.
- R2: After a start condition (data falls while clock is high), when bits [7:1] of the first byte (first bit sent = bit 7) equal `dev_addr_i`, `sda_pd_o` is 1 throughout the high phase of the ninth clock.
- R3: When the address bits do not match, the ninth clock is not acknowledged, and later bytes are neither acknowledged nor stored until the next start condition.
- R4: With address bit 0 equal to 0 (write), every following 8-bit data byte gets `sda_pd_o` = 1 during its ninth clock.
- R5: With `en_i` high, `disp_o` loads when 128 data bits have been received. The first bit received lands in `disp_o[127]` and the last in `disp_o[0]`.
- R6: With `en_i` low, a completed block leaves `disp_o` unchanged. A rising edge on `en_i` while the clock line is high then loads the current shift register into `disp_o`.
- R7: With address bit 0 equal to 1 (read), the slave drives the shift register out oldest bit first (a 1 bit means line released), with the line released on each ninth clock. Reading does not alter the register, so 128 bits later the same sequence repeats. A high (not acknowledged) ninth clock ends the read.
- R8: After the acknowledge of a byte that completes a 128-bit block in write direction, one rising clock edge is ignored, and data reception resumes on the next rising edge.
- R9: A stop condition (data rises while clock is high) returns the slave to idle from any state. Later clocks are not acknowledged before a new start.
- R10: A start condition in the middle of a transfer restarts the address phase.
- R11: `sda_pd_o` never changes while the clock line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock line |
| sda_i | input | 1 | Synchronised bus data line (wired level) |
| en_i | input | 1 | Display load enable: high selects count load, a rising pulse loads directly |
| dev_addr_i | input | ADDR_W (7) | Configured device address |
| sda_pd_o | output | 1 | Pull-down enable for the data line |
| disp_o | output | WORD_BITS (128) | Latched display word |

## Verification
The bench builds the block with its default values: a 7-bit address and a 128-bit word. With these values a real block boundary falls after sixteen acknowledged bytes, so the skipped edge and the streaming of a second block without a new start can be checked. A full read wraps back to the first byte, which shows that readback leaves the register unchanged. Both load modes, address mismatch, stop and repeated start are each driven in a directed scenario.

// File: rtl/tws_pkg.sv
// Shared types for the two-wire display slave.
package tws_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_SKIP,
        ST_RDATA,
        ST_RACK
    } tws_state_e;
endpackage

// File: rtl/tws_events.sv
// Bus event detector: finds clock edges and start/stop conditions.
// Assumes scl_i/sda_i are already synchronised to clk; idle level is high.
module tws_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q, sda_q;

    // Hold the previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/tws_engine.sv
// Protocol engine: address match, acknowledge, write shifting, readback
// rotation and the post-block skipped edge. The pull-down output only
// updates on a falling clock event, so it changes only while clock is low.
module tws_engine
    import tws_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int WORD_BITS = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sda_i,
    input  logic                 scl_rise_i,
    input  logic                 scl_fall_i,
    input  logic                 start_i,
    input  logic                 stop_i,
    input  logic [ADDR_W-1:0]    dev_addr_i,
    output logic                 pd_o,
    output logic                 blk_done_o,
    output logic [WORD_BITS-1:0] shreg_o
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int TOT_W  = $clog2(WORD_BITS);
    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W);
    localparam logic [TOT_W-1:0] TOT_END  = TOT_W'(WORD_BITS - 1);

    tws_state_e           state;
    logic [CNT_W-1:0]     bitcnt;
    logic [TOT_W-1:0]     totcnt;
    logic [BYTE_W-1:0]    addr_sh;
    logic [WORD_BITS-1:0] shreg;
    logic                 rd_mode;
    logic                 blk_pend;

    // Main sequencer: stop and start override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            totcnt     <= '0;
            addr_sh    <= '0;
            shreg      <= '0;
            rd_mode    <= 1'b0;
            blk_pend   <= 1'b0;
            blk_done_o <= 1'b0;
            pd_o       <= 1'b0;
        end else begin
            blk_done_o <= 1'b0;
            if (stop_i) begin
                state <= ST_IDLE;
                pd_o  <= 1'b0;
            end else if (start_i) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                pd_o   <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise_i) begin
                            addr_sh <= {addr_sh[BYTE_W-2:0], sda_i};
                            bitcnt  <= bitcnt + 1'b1;
                        end else if (scl_fall_i && bitcnt == BYTE_END) begin
                            if (addr_sh[BYTE_W-1:1] == dev_addr_i) begin
                                state   <= ST_AACK;
                                pd_o    <= 1'b1;
                                rd_mode <= addr_sh[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall_i) begin
                            bitcnt <= '0;
                            if (rd_mode) begin
                                state <= ST_RDATA;
                                pd_o  <= ~shreg[WORD_BITS-1];
                            end else begin
                                state <= ST_WDATA;
                                pd_o  <= 1'b0;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (scl_rise_i) begin
                            shreg  <= {shreg[WORD_BITS-2:0], sda_i};
                            bitcnt <= bitcnt + 1'b1;
                            if (totcnt == TOT_END) begin
                                totcnt     <= '0;
                                blk_done_o <= 1'b1;
                                blk_pend   <= 1'b1;
                            end else begin
                                totcnt <= totcnt + 1'b1;
                            end
                        end else if (scl_fall_i && bitcnt == BYTE_END) begin
                            state <= ST_WACK;
                            pd_o  <= 1'b1;
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall_i) begin
                            pd_o   <= 1'b0;
                            bitcnt <= '0;
                            if (blk_pend) begin
                                state    <= ST_SKIP;
                                blk_pend <= 1'b0;
                            end else begin
                                state <= ST_WDATA;
                            end
                        end
                    end
                    ST_SKIP: begin
                        if (scl_fall_i) state <= ST_WDATA;
                    end
                    ST_RDATA: begin
                        if (scl_rise_i) begin
                            shreg  <= {shreg[WORD_BITS-2:0], shreg[WORD_BITS-1]};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall_i) begin
                            if (bitcnt == BYTE_END) begin
                                state <= ST_RACK;
                                pd_o  <= 1'b0;
                            end else begin
                                pd_o <= ~shreg[WORD_BITS-1];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise_i && sda_i) begin
                            state <= ST_IDLE;
                        end else if (scl_fall_i) begin
                            state  <= ST_RDATA;
                            bitcnt <= '0;
                            pd_o   <= ~shreg[WORD_BITS-1];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign shreg_o = shreg;
endmodule

// File: rtl/tws_latch.sv
// Display latch: loads on a completed block when enable is high, or on an
// enable rising edge seen while the bus clock is high.
module tws_latch #(
    parameter int WORD_BITS = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 scl_i,
    input  logic                 blk_done_i,
    input  logic [WORD_BITS-1:0] shreg_i,
    output logic [WORD_BITS-1:0] disp_o
);
    logic en_q;

    // Track enable and load the display word on either trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b1;
            disp_o <= '0;
        end else begin
            en_q <= en_i;
            if ((blk_done_i && en_i) || (en_i && !en_q && scl_i))
                disp_o <= shreg_i;
        end
    end
endmodule

// File: rtl/disp_2w_slave.sv
// Top of the two-wire display slave: event detector, protocol engine and
// display latch. Bus inputs must be synchronised to clk beforehand.
module disp_2w_slave #(
    parameter int ADDR_W    = 7,
    parameter int WORD_BITS = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic                 en_i,
    input  logic [ADDR_W-1:0]    dev_addr_i,
    output logic                 sda_pd_o,
    output logic [WORD_BITS-1:0] disp_o
);
    logic                 scl_rise, scl_fall, start_ev, stop_ev, blk_done;
    logic [WORD_BITS-1:0] shreg;

    tws_events u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    tws_engine #(.ADDR_W(ADDR_W), .WORD_BITS(WORD_BITS)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_i      (sda_i),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_ev),
        .stop_i     (stop_ev),
        .dev_addr_i (dev_addr_i),
        .pd_o       (sda_pd_o),
        .blk_done_o (blk_done),
        .shreg_o    (shreg)
    );

    tws_latch #(.WORD_BITS(WORD_BITS)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .scl_i      (scl_i),
        .blk_done_i (blk_done),
        .shreg_i    (shreg),
        .disp_o     (disp_o)
    );
endmodule

// File: rtl/tws_checker.sv
// Port-level properties of the two-wire display slave, bound to the top.
module tws_checker #(
    parameter int WORD_BITS = 128
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 scl_i,
    input logic                 sda_i,
    input logic                 en_i,
    input logic                 sda_pd_o,
    input logic [WORD_BITS-1:0] disp_o
);
    // R1: reset clears the outputs.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (disp_o == '0 && !sda_pd_o));

    // R11: pull-down is steady while the clock line stays high.
    a_r11_pd_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_pd_o));

    // R5 / R6: the display word only changes when enable was high.
    a_r6_load_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(disp_o) |-> $past(en_i));

    // R9: after a stop condition the line is released.
    a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_pd_o);
endmodule

bind disp_2w_slave tws_checker #(.WORD_BITS(WORD_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .en_i     (en_i),
    .sda_pd_o (sda_pd_o),
    .disp_o   (disp_o)
);

// File: tb/tb_disp_2w_slave.sv
// Directed bench for the two-wire display slave; models a wired-AND line.
module tb_disp_2w_slave;
    localparam int CLK_P = 10;
    localparam int AW    = 7;
    localparam int WB    = 128;
    localparam int Q     = 4;
    localparam logic [AW-1:0] MY_ADDR = 7'h3A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl = 1'b1;
    logic          sda_m = 1'b1;
    logic          en = 1'b1;
    logic          pd;
    logic [WB-1:0] disp;
    wire           sda_line = sda_m & ~pd;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    disp_2w_slave #(.ADDR_W(AW), .WORD_BITS(WB)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .en_i       (en),
        .dev_addr_i (MY_ADDR),
        .sda_pd_o   (pd),
        .disp_o     (disp)
    );

    task automatic check(input string req, input logic [WB-1:0] act, input logic [WB-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [WB-1:0] mk_word(input logic [7:0] seed);
        logic [WB-1:0] w;
        for (int i = 0; i < WB/8; i++) w[WB-1-8*i -: 8] = seed + 8'(i * 29);
        return w;
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; wait_q(Q);
        scl = 1'b1;   wait_q(Q);
        sda_m = 1'b0; wait_q(Q);
        scl = 1'b0;   wait_q(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(Q);
        scl = 1'b1;   wait_q(Q);
        sda_m = 1'b1; wait_q(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wait_q(Q);
        scl = 1'b1; wait_q(2*Q);
        scl = 1'b0; wait_q(Q);
    endtask

    // Sends 8 bits then a ninth clock; returns the pull-down seen mid-high.
    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wait_q(Q);
        scl = 1'b1; wait_q(Q);
        ack = pd;
        wait_q(Q);
        scl = 1'b0; wait_q(Q);
    endtask

    // Reads 8 bits then a ninth clock driven by the controller (last = no ack).
    task automatic read_byte(input logic last, output logic [7:0] v, output logic pd9);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q(Q);
            scl = 1'b1; wait_q(Q);
            v[i] = sda_line;
            wait_q(Q);
            scl = 1'b0;
        end
        wait_q(Q);
        sda_m = last; wait_q(Q);
        scl = 1'b1; wait_q(Q);
        pd9 = pd;
        wait_q(Q);
        scl = 1'b0; wait_q(Q);
        sda_m = 1'b1;
    endtask

    task automatic write_block(input logic [WB-1:0] w, input string req);
        logic a;
        for (int i = 0; i < WB/8; i++) begin
            send_byte(w[WB-1-8*i -: 8], a);
            check(req, WB'(a), WB'(1));
        end
    endtask

    task automatic t_reset();
        check("R1 disp after reset", disp, '0);
        check("R1 pd after reset", WB'(pd), '0);
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start();
        send_byte({MY_ADDR ^ 7'h01, 1'b0}, a);
        check("R3 no ack on mismatch", WB'(a), '0);
        for (int i = 0; i < WB/8; i++) begin
            send_byte(8'hC3, a);
            check("R3 data ignored after mismatch", WB'(a), '0);
        end
        bus_stop();
        check("R3 display untouched", disp, '0);
    endtask

    task automatic t_write_count(input logic [WB-1:0] wa, input logic [WB-1:0] wb);
        logic a;
        en = 1'b1;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, a);
        check("R2 write address ack", WB'(a), WB'(1));
        write_block(wa, "R4 byte ack");
        check("R5 count load", disp, wa);
        send_bit(1'b1);
        write_block(wb, "R4 byte ack second block");
        check("R8 skipped edge then second block", disp, wb);
        bus_stop();
    endtask

    task automatic t_write_enable(input logic [WB-1:0] wprev, input logic [WB-1:0] wc);
        logic a;
        en = 1'b0;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, a);
        check("R2 write address ack (en low)", WB'(a), WB'(1));
        write_block(wc, "R4 byte ack en low");
        bus_stop();
        check("R6 no count load with en low", disp, wprev);
        wait_q(Q);
        en = 1'b1; wait_q(Q);
        check("R6 enable pulse load", disp, wc);
    endtask

    task automatic t_read(input logic [WB-1:0] wc);
        logic a, p9;
        logic [7:0] v;
        bus_start();
        send_byte({MY_ADDR, 1'b1}, a);
        check("R2 read address ack", WB'(a), WB'(1));
        for (int i = 0; i < WB/8; i++) begin
            read_byte(1'b0, v, p9);
            check("R7 read byte order", WB'(v), WB'(wc[WB-1-8*i -: 8]));
            check("R7 line released on ninth", WB'(p9), '0);
        end
        read_byte(1'b0, v, p9);
        check("R7 wrap byte 0", WB'(v), WB'(wc[WB-1 -: 8]));
        read_byte(1'b1, v, p9);
        check("R7 wrap byte 1", WB'(v), WB'(wc[WB-9 -: 8]));
        wait_q(Q);
        check("R7 released after no-ack", WB'(pd), '0);
        bus_stop();
    endtask

    task automatic t_stop_mid(input logic [WB-1:0] wc);
        logic a;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, a);
        check("R2 ack before stop test", WB'(a), WB'(1));
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        scl = 1'b0; wait_q(Q);
        send_byte({MY_ADDR, 1'b0}, a);
        check("R9 idle after stop, no ack", WB'(a), '0);
        send_byte(8'h5A, a);
        check("R9 still idle", WB'(a), '0);
        check("R9 display kept", disp, wc);
        scl = 1'b1; wait_q(Q);
    endtask

    task automatic t_restart();
        logic a, p9;
        logic [7:0] v;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, a);
        check("R10 first address ack", WB'(a), WB'(1));
        send_bit(1'b1); send_bit(1'b0);
        bus_start();
        send_byte({MY_ADDR, 1'b1}, a);
        check("R10 restart address ack", WB'(a), WB'(1));
        read_byte(1'b1, v, p9);
        check("R10 ninth released in read", WB'(p9), '0);
        wait_q(Q);
        bus_stop();
        bus_start();
        send_byte({MY_ADDR ^ 7'h40, 1'b0}, a);
        check("R10 restart with other address, no ack", WB'(a), '0);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [WB-1:0] wa, wb, wc;
        wa = mk_word(8'h11);
        wb = mk_word(8'h80);
        wc = mk_word(8'hE7);
        wait_q(5);
        t_reset();
        rst_n = 1'b1;
        wait_q(3);
        t_reset();
        t_mismatch();
        t_write_count(wa, wb);
        t_write_enable(wb, wc);
        t_read(wc);
        t_stop_mid(wc);
        t_restart();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule